// File: doc/BRIEF.md
# Serial DAC Write-Frame Receiver

This block receives write frames for an 8-bit voltage-output converter over a three-wire serial link. The link has an active-low frame-sync line, a serial clock and a data line. All three lines are oversampled in the system clock domain through a synchronizer chain. A frame is a 16-bit word, shifted in most significant bit first on falling serial-clock edges while sync is low. The word carries a 2-bit operating-mode field and an 8-bit converter code. When the sixteenth bit arrives, both held registers are written at once and a one-cycle update strobe is raised for downstream logic.

Sync must stay high for a minimum number of system clocks between frames. A falling edge of sync that comes too early is flagged and its frame is refused. The block also reports the ideal output level for the held code as a number: full scale times code / 256 in normal mode, and zero in any power-down mode. No analog behaviour is modelled.

Top module: `dac_frame_rx`

## Requirements
- R1: After reset, code_o is 0, mode_o is 00 (normal), level_o is 0, update_o and timing_err_o are 0, and the receiver waits for a falling edge of fsync_n.
- R2: A frame is opened only by a falling edge of fsync_n that follows at least MIN_GAP synchronized system cycles of fsync_n high. While fsync_n stays low, the data bit is captured on each falling edge of sclk, first bit = word bit 15.
- R3: On the sixteenth captured bit, code_o takes word bits [11:4]. Bits [13:12] and [3:0] have no effect.
- R4: On the sixteenth captured bit, mode_o takes word bits [15:14] (00 normal, 01/10/11 power-down). Every accepted frame writes both mode and code.
- R5: update_o is high for exactly one cycle, in the same cycle as the new code_o/mode_o values. That cycle is SYNC_STAGES clocks after the clock edge that first samples the sixteenth sclk fall. code_o and mode_o change in no other cycle.
- R6: level_o equals floor(code_o * FULL_SCALE / 256) when mode_o is 00, and 0 otherwise.
- R7: If fsync_n rises before sixteen bits have been captured, the partial frame is discarded: no update pulse, and code_o/mode_o are unchanged.
- R8: sclk falling edges after the sixteenth bit, while fsync_n stays low, are ignored until fsync_n rises and falls again.
- R9: A falling edge of fsync_n after fewer than MIN_GAP synchronized high cycles raises timing_err_o for one cycle. That frame is refused and leaves code_o/mode_o unchanged.
- R10: fsync_n rising after a completed frame has no effect on code_o, mode_o or update_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_n | input | 1 | Frame sync, active low, asynchronous |
| sclk | input | 1 | Serial clock, data captured on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| code_o | output | CODE_W (8) | Held converter code |
| mode_o | output | 2 | Held operating mode |
| level_o | output | LEVEL_W (16) | Ideal output level for the held code |
| update_o | output | 1 | One-cycle strobe when a frame is executed |
| timing_err_o | output | 1 | One-cycle strobe when sync fell too early |

## Verification
The assertions assume that every frame needs at least several system clocks per serial bit. Under that assumption two update strobes can never fall in adjacent cycles. They also assume that the data line is stable across each falling serial-clock edge, so the sampled bit is well defined. The stimulus keeps to both assumptions. It holds each serial-clock phase for three system clocks and changes data only while sclk is high. Sync is moved only on system-clock half cycles, well away from serial-clock falls, except in the scenarios that deliberately cut a frame short or shorten the sync-high gap.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_RUN     = 2'b00,
      MODE_SLEEP_A = 2'b01,
      MODE_SLEEP_B = 2'b10,
      MODE_SLEEP_C = 2'b11
   } dac_mode_e;

   // index of each line inside the synchronizer bundle
   localparam int LN_SYNC = 2;
   localparam int LN_SCLK = 1;
   localparam int LN_DATA = 0;
   localparam logic [2:0] LINES_IDLE = 3'b110;
endpackage

// File: rtl/dac_frame_sync.sv
module dac_frame_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fsync_n,
   input  logic sclk,
   input  logic sdin,
   output logic sync_hi,
   output logic sync_fall,
   output logic sclk_fall,
   output logic data_bit
);
   import dac_frame_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("dac_frame_sync: STAGES must be at least 2");
   end

   logic [2:0] chain [STAGES];
   logic       sync_prev, sclk_prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= LINES_IDLE;
            else        chain[0] <= {fsync_n, sclk, sdin};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= LINES_IDLE;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_prev <= LINES_IDLE[LN_SYNC];
         sclk_prev <= LINES_IDLE[LN_SCLK];
      end else begin
         sync_prev <= chain[STAGES-1][LN_SYNC];
         sclk_prev <= chain[STAGES-1][LN_SCLK];
      end
   end

   assign sync_hi   = chain[STAGES-1][LN_SYNC];
   assign sync_fall = sync_prev & ~sync_hi;
   assign sclk_fall = sclk_prev & ~chain[STAGES-1][LN_SCLK];
   assign data_bit  = chain[STAGES-1][LN_DATA];
endmodule

// File: rtl/dac_frame_gap.sv
module dac_frame_gap #(
   parameter int MIN_GAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_hi,
   input  logic sync_fall,
   output logic start,
   output logic timing_err
);
   localparam int CW = $clog2(MIN_GAP + 1);
   localparam logic [CW-1:0] GAP_MAX = CW'(MIN_GAP);

   if (MIN_GAP < 1) begin : g_bad_gap
      $error("dac_frame_gap: MIN_GAP must be at least 1");
   end

   logic [CW-1:0] hi_cnt;
   logic          gap_ok;

   assign gap_ok = (hi_cnt >= GAP_MAX);
   assign start  = sync_fall & gap_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt     <= GAP_MAX;
         timing_err <= 1'b0;
      end else begin
         timing_err <= sync_fall & ~gap_ok;
         if (!sync_hi)     hi_cnt <= '0;
         else if (!gap_ok) hi_cnt <= hi_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift #(
   parameter int FRAME_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sync_hi,
   input  logic                  start,
   input  logic                  sclk_fall,
   input  logic                  data_bit,
   output logic                  done,
   output logic [FRAME_BITS-1:0] word_next
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] word;
   logic [CNT_W-1:0]      cnt;
   logic                  active;
   logic                  take;

   assign take      = active & ~sync_hi & ~start & sclk_fall;
   assign word_next = {word[FRAME_BITS-2:0], data_bit};
   assign done      = take & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word   <= '0;
         cnt    <= '0;
         active <= 1'b0;
      end else if (start) begin
         cnt    <= '0;
         active <= 1'b1;
      end else if (sync_hi) begin
         active <= 1'b0;
      end else if (take) begin
         word <= word_next;
         cnt  <= cnt + 1'b1;
         if (cnt == LAST) active <= 1'b0;
      end
   end
endmodule

// File: rtl/dac_frame_regs.sv
module dac_frame_regs #(
   parameter int FRAME_BITS = 16,
   parameter int CODE_W     = 8,
   parameter int CODE_LSB   = 4,
   parameter int LEVEL_W    = 16,
   parameter int FULL_SCALE = 3300,
   parameter bit LEVEL_EN   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  done,
   input  logic [FRAME_BITS-1:0] word,
   output logic [CODE_W-1:0]     code,
   output dac_frame_pkg::dac_mode_e mode,
   output logic                  update,
   output logic [LEVEL_W-1:0]    level
);
   import dac_frame_pkg::*;

   localparam int CODE_MSB = CODE_LSB + CODE_W - 1;
   localparam int MODE_LSB = FRAME_BITS - MODE_W;
   localparam int PROD_W   = CODE_W + LEVEL_W;

   if (CODE_MSB >= MODE_LSB) begin : g_bad_fields
      $error("dac_frame_regs: code field overlaps mode field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code   <= '0;
         mode   <= MODE_RUN;
         update <= 1'b0;
      end else begin
         update <= done;
         if (done) begin
            code <= word[CODE_MSB:CODE_LSB];
            mode <= dac_mode_e'(word[FRAME_BITS-1:MODE_LSB]);
         end
      end
   end

   if (LEVEL_EN) begin : g_level
      logic [PROD_W-1:0] prod;
      assign prod  = PROD_W'(code) * PROD_W'(FULL_SCALE);
      assign level = (mode == MODE_RUN) ? prod[CODE_W +: LEVEL_W] : '0;
   end else begin : g_no_level
      assign level = '0;
   end
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
   parameter int FRAME_BITS  = 16,
   parameter int CODE_W      = 8,
   parameter int CODE_LSB    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_GAP     = 4,
   parameter int LEVEL_W     = 16,
   parameter int FULL_SCALE  = 3300,
   parameter bit LEVEL_EN    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fsync_n,
   input  logic               sclk,
   input  logic               sdin,
   output logic [CODE_W-1:0]  code_o,
   output logic [1:0]         mode_o,
   output logic [LEVEL_W-1:0] level_o,
   output logic               update_o,
   output logic               timing_err_o
);
   import dac_frame_pkg::*;

   if (FULL_SCALE >= (1 << LEVEL_W)) begin : g_bad_scale
      $error("dac_frame_rx: FULL_SCALE does not fit LEVEL_W");
   end

   logic sync_hi, sync_fall, sclk_fall, data_bit, start, done;
   logic [FRAME_BITS-1:0] word_next;
   dac_mode_e             mode_q;

   dac_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .fsync_n, .sclk, .sdin,
      .sync_hi, .sync_fall, .sclk_fall, .data_bit
   );

   dac_frame_gap #(.MIN_GAP(MIN_GAP)) u_gap (
      .clk, .rst_n, .sync_hi, .sync_fall,
      .start, .timing_err(timing_err_o)
   );

   dac_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
      .clk, .rst_n, .sync_hi, .start, .sclk_fall, .data_bit,
      .done, .word_next
   );

   dac_frame_regs #(
      .FRAME_BITS(FRAME_BITS), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB),
      .LEVEL_W(LEVEL_W), .FULL_SCALE(FULL_SCALE), .LEVEL_EN(LEVEL_EN)
   ) u_regs (
      .clk, .rst_n, .done, .word(word_next),
      .code(code_o), .mode(mode_q), .update(update_o), .level(level_o)
   );

   assign mode_o = mode_q;
endmodule

// File: rtl/dac_frame_rx_chk.sv
module dac_frame_rx_chk #(
   parameter int CODE_W     = 8,
   parameter int LEVEL_W    = 16,
   parameter int FULL_SCALE = 3300
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fsync_n,
   input logic               sclk,
   input logic               sdin,
   input logic [CODE_W-1:0]  code_o,
   input logic [1:0]         mode_o,
   input logic [LEVEL_W-1:0] level_o,
   input logic               update_o,
   input logic               timing_err_o
);
   // R5: strobe lasts one cycle
   a_r5_update_single: assert property (@(posedge clk) disable iff (!rst_n)
      update_o |=> !update_o);

   // R5: code only moves with the strobe
   a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !update_o |-> $stable(code_o));

   // R4: mode only moves with the strobe
   a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !update_o |-> $stable(mode_o));

   // R6: level stays below full scale
   a_r6_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      level_o < LEVEL_W'(FULL_SCALE));

   // R9: a refused frame cannot execute right after the error
   a_r9_err_no_update: assert property (@(posedge clk) disable iff (!rst_n)
      timing_err_o |=> !update_o);

   // R9: error and strobe never coincide
   a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(timing_err_o && update_o));

   // R9: error is a single-cycle pulse
   a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      timing_err_o |=> !timing_err_o);
endmodule

bind dac_frame_rx dac_frame_rx_chk #(
   .CODE_W(CODE_W), .LEVEL_W(LEVEL_W), .FULL_SCALE(FULL_SCALE)
) u_chk (.*);

// File: tb/dac_frame_rx_tb.sv
module dac_frame_rx_tb;
   localparam int N    = 2;
   localparam int GAP  = 4;
   localparam int FS   = 3300;
   localparam int HALF = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fsync_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
   logic [7:0]  code_o;
   logic [1:0]  mode_o;
   logic [15:0] level_o;
   logic        update_o, timing_err_o;

   always #5 clk = ~clk;

   dac_frame_rx u_dut (
      .clk, .rst_n, .fsync_n, .sclk, .sdin,
      .code_o, .mode_o, .level_o, .update_o, .timing_err_o
   );

   int compared = 0, mismatched = 0;
   int upd_seen = 0, err_seen = 0;

   // behavioural reference
   bit hs[$], hc[$], hd[$];
   bit m_active, m_upd, m_err;
   int m_cnt, m_hi, m_code, m_mode;
   bit [15:0] m_word;

   task automatic model_reset();
      hs = {}; hc = {}; hd = {};
      for (int i = 0; i <= N; i++) begin
         hs.push_back(1'b1); hc.push_back(1'b1); hd.push_back(1'b0);
      end
      m_active = 0; m_upd = 0; m_err = 0;
      m_cnt = 0; m_hi = GAP; m_code = 0; m_mode = 0; m_word = '0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         bit cs, ps, cc, pc, cd;
         int hi_old;
         cs = hs[N-1]; ps = hs[N]; cc = hc[N-1]; pc = hc[N]; cd = hd[N-1];
         hi_old = m_hi;
         m_upd = 0; m_err = 0;
         if (cs) m_hi = (m_hi < GAP) ? m_hi + 1 : GAP; else m_hi = 0;
         if (ps && !cs) begin
            if (hi_old < GAP) m_err = 1;
            else begin m_active = 1; m_cnt = 0; end
         end else if (cs) m_active = 0;
         else if (m_active && pc && !cc) begin
            m_word = {m_word[14:0], cd};
            m_cnt++;
            if (m_cnt == 16) begin
               m_active = 0; m_upd = 1;
               m_code = m_word[11:4]; m_mode = m_word[15:14];
            end
         end
         hs.push_front(fsync_n); void'(hs.pop_back());
         hc.push_front(sclk);    void'(hc.pop_back());
         hd.push_front(sdin);    void'(hd.pop_back());
      end
   end

   task automatic cmp(string tag, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      int lvl;
      lvl = (m_mode == 0) ? (m_code * FS) / 256 : 0;
      cmp("R3 code_o", code_o, m_code);
      cmp("R4 mode_o", mode_o, m_mode);
      cmp("R6 level_o", level_o, lvl);
      cmp("R5 update_o", update_o, m_upd);
      cmp("R9 timing_err_o", timing_err_o, m_err);
      if (update_o) upd_seen++;
      if (timing_err_o) err_seen++;
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(bit [15:0] w, int nbits);
      for (int i = 15; i > 15 - nbits; i--) begin
         sdin = w[i]; sclk = 1'b1; wait_cyc(HALF);
         sclk = 1'b0; wait_cyc(HALF);
      end
      sclk = 1'b1;
   endtask

   task automatic frame(bit [15:0] w, int nbits, int tail);
      fsync_n = 1'b0; wait_cyc(HALF);
      shift_bits(w, nbits);
      wait_cyc(HALF + tail);
      fsync_n = 1'b1; wait_cyc(10);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int u0;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(2);
      // R1 reset state
      cmp("R1 reset code", code_o, 0);
      cmp("R1 reset mode", mode_o, 0);
      cmp("R1 reset level", level_o, 0);
      cmp("R1 reset update", update_o, 0);
      wait_cyc(6);

      frame(16'h0A50, 16, 0);
      cmp("R3 code A5", code_o, 8'hA5);
      cmp("R6 level A5", level_o, (165 * FS) / 256);

      frame(16'h0FF0, 16, 0);
      cmp("R6 level max code", level_o, (255 * FS) / 256);

      frame(16'h0000, 16, 0);
      cmp("R6 level zero code", level_o, 0);

      frame(16'hB3CF, 16, 0);
      cmp("R4 mode sleep", mode_o, 2);
      cmp("R3 code 3C ignores reserved", code_o, 8'h3C);
      cmp("R6 level in sleep", level_o, 0);

      u0 = upd_seen;
      frame(16'h4777, 10, 0);
      cmp("R7 partial no update", upd_seen - u0, 0);
      cmp("R7 partial code kept", code_o, 8'h3C);
      cmp("R7 partial mode kept", mode_o, 2);

      u0 = upd_seen;
      fsync_n = 1'b0; wait_cyc(HALF);
      shift_bits(16'h1230, 16);
      shift_bits(16'hFFFF, 16);
      wait_cyc(HALF);
      cmp("R8 extra clocks ignored code", code_o, 8'h23);
      cmp("R8 one update only", upd_seen - u0, 1);
      u0 = upd_seen;
      fsync_n = 1'b1; wait_cyc(10);
      cmp("R10 sync rise no effect", upd_seen - u0, 0);
      cmp("R10 code kept", code_o, 8'h23);
      cmp("R4 mode normal", mode_o, 0);

      // short sync-high gap
      fsync_n = 1'b0; wait_cyc(6);
      fsync_n = 1'b1; wait_cyc(2);
      u0 = upd_seen;
      frame(16'h0550, 16, 0);
      cmp("R9 error flagged", err_seen, 1);
      cmp("R9 frame refused", upd_seen - u0, 0);
      cmp("R9 code kept", code_o, 8'h23);

      frame(16'h0550, 16, 0);
      cmp("R2 frame after valid gap", code_o, 8'h55);
      cmp("R2 no extra error", err_seen, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule